// File: doc/BRIEF.md
# Sequential Dial Combination Lock

This block is a clocked state machine that guards a lock opened by a rotary dial. Each dial operation arrives as a single event. A one-cycle strobe marks the event, a direction bit says which way the dial was turned, and a six-bit value gives the number it stopped on (0 to 39). The lock opens only when three operations arrive in a set order. The direction of each operation counts as much as its number. By default the order is right to 13, then left to 22, then right to 3. All three steps are parameters.

The state is held in two bits. The four states are `ST_IDLE` (nothing useful done yet), `ST_STEP1` (first step done), `ST_STEP2` (second step done) and `ST_OPEN`. The state changes only on a strobed operation, on `relock`, or on reset. It never advances just because a clock edge went by.

The named transitions are:
- **advance**: the operation matches the step expected next. The machine moves one state forward. From `ST_STEP2` it moves to `ST_OPEN`.
- **restart**: the operation does not match the expected step but equals the first step. The machine goes to `ST_STEP1`.
- **fallback**: any other operation that does not match. The machine goes to `ST_IDLE`.
- **hold**: there is no strobe, or the machine is in `ST_OPEN`. The state does not change.
- **relock**: the machine goes to `ST_IDLE` from any state.

The `unlocked` output is a Moore output taken from the state.

Top module: `dial_lock_top`

## Requirements
- R1: A synchronous active-high `rst` puts the machine in `ST_IDLE` with `unlocked` low at the next clock edge. This holds in every state, including partway through a sequence.
- R2: `op_dir`, where 1 means right and 0 means left, and the 6-bit `op_value` are sampled only in cycles where `op_valid` is 1. In a cycle with `op_valid` at 0 the state stays the same, whatever those inputs hold.
- R3: Three strobed operations matching steps one, two and three in that order drive `unlocked` high from the clock edge that samples the third operation.
- R4: `unlocked` is 1 only in `ST_OPEN`. It is 0 in `ST_IDLE`, `ST_STEP1` and `ST_STEP2`.
- R5: An operation with the right value but the wrong direction counts as a mismatch.
- R6: In `ST_IDLE`, `ST_STEP1` or `ST_STEP2`, an operation that does not match the expected step moves the machine to `ST_STEP1` if it equals step one, and to `ST_IDLE` otherwise.
- R7: In `ST_OPEN`, strobed operations of any direction and value are ignored, and `unlocked` stays 1.
- R8: `relock` at 1 moves the machine to `ST_IDLE` at the next edge from any state. It takes priority over a strobed operation in the same cycle, and that operation is discarded.
- R9: The steps are parameters. Their defaults are right-13, left-22, right-3.
- R10: A value above 39 never matches any step.
- R11: Any number of cycles without a strobe may pass between the operations of a sequence.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| op_valid | input | 1 | One-cycle strobe marking a dial operation |
| op_dir | input | 1 | Direction of the operation: 1 is right, 0 is left |
| op_value | input | 6 | Number the dial stopped on |
| relock | input | 1 | Returns the machine to the idle state |
| unlocked | output | 1 | High while the lock is open |

## Verification
The correct sequence is applied in two forms: with strobes back to back, and with idle gaps between them. When the gaps hold the next step's direction and value with the strobe low, this separates event-driven advance from clock-driven advance. Some sequences reuse the right numbers with a wrong direction, and some use values above 39. These show that direction and range are part of a match. Some sequences repeat the first step partway through. These separate the restart transition from the fallback transition. Relock, and reset in mid-sequence, are applied together with strobes. Every clock, the output is compared with a behavioural model that tracks progress along the sequence.

// File: rtl/dial_lock_pkg.sv
package dial_lock_pkg;

    // Two state bits hold the four states.
    typedef enum logic [1:0] {
        ST_IDLE  = 2'b00,
        ST_STEP1 = 2'b01,
        ST_STEP2 = 2'b10,
        ST_OPEN  = 2'b11
    } lock_state_t;

    localparam int N_STEPS = 3;

endpackage

// File: rtl/dial_step_match.sv
module dial_step_match #(
    parameter int DIAL_W     = 6,
    parameter int DIAL_MAX   = 39,
    parameter bit STEP_DIR   = 1'b1,
    parameter int STEP_VALUE = 13
) (
    input  logic              op_dir,
    input  logic [DIAL_W-1:0] op_value,
    output logic              hit
);

    localparam logic [DIAL_W-1:0] MAX_V  = DIAL_W'(DIAL_MAX);
    localparam logic [DIAL_W-1:0] STEP_V = DIAL_W'(STEP_VALUE);

    logic in_range;

    always_comb begin
        in_range = (op_value <= MAX_V);
        hit      = in_range && (op_dir == STEP_DIR) && (op_value == STEP_V);
    end

endmodule

// File: rtl/dial_next_state.sv
module dial_next_state
    import dial_lock_pkg::*;
(
    input  lock_state_t        cur_state,
    input  logic               op_valid,
    input  logic               relock,
    input  logic [N_STEPS-1:0] step_hit,
    output lock_state_t        nxt_state
);

    logic expect_hit;

    // Pick the match flag of the step this state expects next.
    always_comb begin
        unique case (cur_state)
            ST_IDLE:  expect_hit = step_hit[0];
            ST_STEP1: expect_hit = step_hit[1];
            ST_STEP2: expect_hit = step_hit[2];
            ST_OPEN:  expect_hit = 1'b0;
        endcase
    end

    always_comb begin
        nxt_state = cur_state;
        if (relock) begin
            nxt_state = ST_IDLE;
        end else if (op_valid) begin
            unique case (cur_state)
                ST_IDLE, ST_STEP1, ST_STEP2: begin
                    if (expect_hit) begin
                        unique case (cur_state)
                            ST_IDLE:  nxt_state = ST_STEP1;
                            ST_STEP1: nxt_state = ST_STEP2;
                            default:  nxt_state = ST_OPEN;
                        endcase
                    end else if (step_hit[0]) begin
                        nxt_state = ST_STEP1;
                    end else begin
                        nxt_state = ST_IDLE;
                    end
                end
                ST_OPEN: nxt_state = ST_OPEN;
            endcase
        end
    end

endmodule

// File: rtl/dial_lock_top.sv
module dial_lock_top
    import dial_lock_pkg::*;
#(
    parameter int DIAL_W   = 6,
    parameter int DIAL_MAX = 39,
    parameter bit S1_DIR   = 1'b1,
    parameter int S1_VALUE = 13,
    parameter bit S2_DIR   = 1'b0,
    parameter int S2_VALUE = 22,
    parameter bit S3_DIR   = 1'b1,
    parameter int S3_VALUE = 3
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              op_valid,
    input  logic              op_dir,
    input  logic [DIAL_W-1:0] op_value,
    input  logic              relock,
    output logic              unlocked
);

    lock_state_t        state_q;
    lock_state_t        state_d;
    logic [N_STEPS-1:0] step_hit;

    // R9: one comparator per step, each set by its own parameters.
    for (genvar g = 0; g < N_STEPS; g++) begin : g_step
        localparam bit G_DIR = (g == 0) ? S1_DIR   : (g == 1) ? S2_DIR   : S3_DIR;
        localparam int G_VAL = (g == 0) ? S1_VALUE : (g == 1) ? S2_VALUE : S3_VALUE;
        dial_step_match #(
            .DIAL_W    (DIAL_W),
            .DIAL_MAX  (DIAL_MAX),
            .STEP_DIR  (G_DIR),
            .STEP_VALUE(G_VAL)
        ) u_match (
            .op_dir  (op_dir),
            .op_value(op_value),
            .hit     (step_hit[g])
        );
    end

    dial_next_state u_next (
        .cur_state(state_q),
        .op_valid (op_valid),
        .relock   (relock),
        .step_hit (step_hit),
        .nxt_state(state_d)
    );

    // State register.
    always_ff @(posedge clk) begin
        if (rst) state_q <= ST_IDLE;
        else     state_q <= state_d;
    end

    // Moore output.
    always_comb begin
        unique case (state_q)
            ST_OPEN: unlocked = 1'b1;
            default: unlocked = 1'b0;
        endcase
    end

    // R8
    relock_clears_chk: assert property (@(posedge clk) disable iff (rst)
        relock |=> !unlocked);

    // R7
    open_holds_chk: assert property (@(posedge clk) disable iff (rst)
        (unlocked && !relock) |=> unlocked);

    // R2
    no_strobe_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (!op_valid && !relock) |=> $stable(state_q));

    // R3
    open_needs_event_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(unlocked) |-> $past(op_valid));

    // R3
    final_step_opens_chk: assert property (@(posedge clk) disable iff (rst)
        (state_q == ST_STEP2 && op_valid && !relock && step_hit[2]) |=> unlocked);

    // R6
    restart_chk: assert property (@(posedge clk) disable iff (rst)
        (state_q == ST_STEP1 && op_valid && !relock && !step_hit[1] && step_hit[0])
            |=> (state_q == ST_STEP1));

endmodule

// File: tb/tb_dial_lock_top.sv
module tb_dial_lock_top;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       op_valid = 1'b0;
    logic       op_dir = 1'b0;
    logic [5:0] op_value = '0;
    logic       relock = 1'b0;
    logic       unlocked;

    int n_cmp = 0;
    int n_bad = 0;
    int prog  = 0;   // reference: 0..2 steps done, 3 = open

    int seq_dir [3] = '{1, 0, 1};
    int seq_val [3] = '{13, 22, 3};

    always #5 clk = ~clk;

    dial_lock_top dut (
        .clk(clk), .rst(rst), .op_valid(op_valid), .op_dir(op_dir),
        .op_value(op_value), .relock(relock), .unlocked(unlocked)
    );

    function automatic bit is_step(int k, bit d, int v);
        return (v <= 39) && (d == seq_dir[k]) && (v == seq_val[k]);
    endfunction

    // One clock: drive at negedge, update model at posedge, compare at next negedge.
    task automatic cyc(bit v, bit d, int val, bit rl, bit rs, string tag);
        op_valid = v; op_dir = d; op_value = 6'(val); relock = rl; rst = rs;
        @(posedge clk);
        if (rs || rl)        prog = 0;
        else if (prog == 3)  prog = 3;
        else if (v) begin
            if (is_step(prog, d, val)) prog = prog + 1;
            else if (is_step(0, d, val)) prog = 1;
            else prog = 0;
        end
        @(negedge clk);
        n_cmp++;
        if (unlocked !== (prog == 3)) begin
            n_bad++;
            $display("FAIL %s: unlocked=%b expected=%b", tag, unlocked, (prog == 3));
        end
    endtask

    task automatic op(bit d, int val, string tag);
        cyc(1'b1, d, val, 1'b0, 1'b0, tag);
    endtask

    task automatic gap(int n, string tag);
        for (int i = 0; i < n; i++) cyc(1'b0, 1'b1, 3, 1'b0, 1'b0, tag);
    endtask

    task automatic do_relock(string tag);
        cyc(1'b0, 1'b0, 0, 1'b1, 1'b0, tag);
    endtask

    initial begin
        #2000000;
        n_bad++;
        $display("FAIL watchdog: run did not finish, actual=hung expected=done");
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        @(negedge clk);
        // R1 reset state
        cyc(1'b0, 1'b0, 0, 1'b0, 1'b1, "R1 reset");
        cyc(1'b0, 1'b0, 0, 1'b0, 1'b1, "R1 reset");
        gap(3, "R2 idle no strobe");

        // R3, R11, R2: correct sequence with gaps, step data held while strobe low
        op(1'b1, 13, "R3 step1");
        cyc(1'b0, 1'b0, 22, 1'b0, 1'b0, "R2 value without strobe");
        cyc(1'b0, 1'b1, 3, 1'b0, 1'b0, "R2 value without strobe");
        gap(4, "R11 gap");
        op(1'b0, 22, "R4 step2 still closed");
        gap(2, "R11 gap");
        op(1'b1, 3, "R3 opens");
        // R7 operations while open
        op(1'b0, 5, "R7 ignored");
        op(1'b1, 13, "R7 ignored");
        op(1'b1, 63, "R7 ignored");
        gap(2, "R7 stays open");

        // R8 relock, then relock together with a strobe
        do_relock("R8 relock");
        cyc(1'b1, 1'b1, 13, 1'b1, 1'b0, "R8 relock beats strobe");
        op(1'b0, 22, "R8 discarded first step");
        op(1'b1, 3, "R8 must stay closed");

        // R9 default combination back to back
        do_relock("R8 relock");
        op(1'b1, 13, "R9 default");
        op(1'b0, 22, "R9 default");
        op(1'b1, 3, "R9 default opens");
        do_relock("R8 relock");

        // R5 wrong direction
        op(1'b0, 13, "R5 left13");
        op(1'b0, 22, "R5");
        op(1'b1, 3, "R5 closed");
        op(1'b1, 13, "R5");
        op(1'b1, 22, "R5 right22");
        op(1'b1, 3, "R5 closed");
        op(1'b1, 13, "R5");
        op(1'b0, 22, "R5");
        op(1'b0, 3, "R5 left3");
        gap(1, "R5 closed");

        // R6 restart and fallback
        op(1'b1, 13, "R6");
        op(1'b1, 13, "R6 repeat first");
        op(1'b0, 22, "R6");
        op(1'b1, 3, "R6 opens after restart");
        do_relock("R8 relock");
        op(1'b1, 13, "R6");
        op(1'b0, 22, "R6");
        op(1'b1, 13, "R6 restart from step2");
        op(1'b0, 22, "R6");
        op(1'b1, 3, "R6 opens");
        do_relock("R8 relock");
        op(1'b1, 13, "R6");
        op(1'b0, 7, "R6 fallback");
        op(1'b0, 22, "R6");
        op(1'b1, 3, "R6 closed after fallback");

        // R10 out-of-range values
        op(1'b1, 53, "R10");
        op(1'b0, 22, "R10");
        op(1'b1, 3, "R10 closed");
        op(1'b1, 13, "R10");
        op(1'b0, 62, "R10");
        op(1'b1, 3, "R10 closed");
        op(1'b1, 13, "R10");
        op(1'b0, 22, "R10");
        op(1'b1, 43, "R10 closed");

        // R1 reset mid-sequence and while open
        op(1'b1, 13, "R1");
        op(1'b0, 22, "R1");
        cyc(1'b1, 1'b1, 3, 1'b0, 1'b1, "R1 reset beats strobe");
        op(1'b1, 3, "R1 closed after reset");
        op(1'b1, 13, "R1");
        op(1'b0, 22, "R1");
        op(1'b1, 3, "R1 open");
        cyc(1'b0, 1'b0, 0, 1'b0, 1'b1, "R1 reset from open");
        gap(2, "R4 closed idle");

        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

endmodule